// File: doc/BRIEF.md
# Non-Revertive Two-Input Reference Selector

The block decides which of two reference clocks is routed to a phase detector. It drives only the select line of the reference multiplexer. An acknowledge output reports the chosen input, and a one-cycle event marks every change of that choice. In manual mode the choice follows a select pin. In automatic mode the block watches the fault flag of the working input. When that flag goes up, the block moves to the other input by itself.

One automatic move is allowed per arming, and the selection never reverts. After the move, the select pin is locked out. To arm the block again, software must drop the mode pin to return to manual mode, set the select pin to the input it wants, and raise the mode pin again. The controller has three named states: MANUAL, ARMED and SWITCHED. Its transitions are:
- ARM: MANUAL to ARMED when the mode pin is high.
- FAILOVER: ARMED to SWITCHED on a rising fault of the working input.
- DISARM: ARMED or SWITCHED to MANUAL when the mode pin is low.
- STAY: every state holds otherwise.

Top module: `refsw_ctrl`

## Requirements
- R1: After reset the controller is in MANUAL, with `mux_sel` = 0, `ref_ack` = 0 and `resel_evt` = 0.
- R2: While `auto_mode` is 0, `mux_sel` takes the value of `man_sel` at the next clock edge (1 selects input 1, 0 selects input 0).
- R3: `ref_ack` always equals `mux_sel` (1 means input 1 is routed, 0 means input 0).
- R4: At the edge where `auto_mode` is first seen high (ARM), the working input is taken from `man_sel`. While ARMED, a change of `man_sel` has no effect.
- R5: While ARMED, a 0-to-1 change of `fault[mux_sel]` (bit 0 is input 0, bit 1 is input 1) makes `mux_sel` switch to the other input at the next edge (FAILOVER).
- R6: While ARMED, a fault on the input that is not working causes no switch.
- R7: In SWITCHED with `auto_mode` high, `mux_sel` does not change, even when the new input also reports a fault.
- R8: In SWITCHED, `man_sel` has no effect until `auto_mode` goes low.
- R9: A low `auto_mode` in ARMED or SWITCHED returns to MANUAL (DISARM). A later high `auto_mode` arms again, which allows one more automatic switch.
- R10: `resel_evt` is high for exactly the one cycle that follows each change of `mux_sel`, whether the change was manual or automatic, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_mode | input | 1 | 1 = automatic reselection, 0 = manual |
| man_sel | input | 1 | Manual select pin |
| fault | input | 2 | Per-input fault flags, bit i for input i |
| mux_sel | output | 1 | Reference multiplexer select |
| ref_ack | output | 1 | Reports the routed input |
| resel_evt | output | 1 | One-cycle pulse on each select change |

## Verification
The assertions assume that `auto_mode`, `man_sel` and `fault` are synchronous to `clk` and are held steady around each edge. The stimulus changes them only at falling edges. It holds `auto_mode` low through reset, and it arms the controller only while the working input's fault flag is low, because the failover responds to a rising flag and not to its level. The sequence covers a failover onto an input that is also faulty, select-pin toggles both while armed and after a switch, and a second arming that fails over in the other direction.

// File: rtl/refsw_pkg.sv
package refsw_pkg;
    localparam int NUM_REF = 2;
    localparam int SEL_W   = $clog2(NUM_REF);

    typedef enum logic [1:0] {
        ST_MANUAL   = 2'd0,
        ST_ARMED    = 2'd1,
        ST_SWITCHED = 2'd2
    } refsw_state_e;
endpackage

// File: rtl/refsw_edge.sv
module refsw_edge #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] lvl_q;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q[gi] <= 1'b0;
            else        lvl_q[gi] <= lvl[gi];
        end
        assign rise[gi] = lvl[gi] & ~lvl_q[gi];
    end
endmodule

// File: rtl/refsw_fsm.sv
module refsw_fsm
    import refsw_pkg::*;
#(
    parameter int N = NUM_REF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         auto_mode,
    input  logic         man_sel,
    input  logic [N-1:0] rise,
    output refsw_state_e state,
    output logic         sel,
    output logic         sel_next
);
    refsw_state_e state_next;
    logic         work_rise;

    assign work_rise = rise[sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_MANUAL;
            sel   <= 1'b0;
        end else begin
            state <= state_next;
            sel   <= sel_next;
        end
    end

    always_comb begin
        state_next = state;
        sel_next   = sel;
        unique case (state)
            ST_MANUAL: begin
                sel_next = man_sel;
                if (auto_mode) state_next = ST_ARMED;
            end
            ST_ARMED: begin
                if (!auto_mode) begin
                    state_next = ST_MANUAL;
                    sel_next   = man_sel;
                end else if (work_rise) begin
                    state_next = ST_SWITCHED;
                    sel_next   = ~sel;
                end
            end
            ST_SWITCHED: begin
                if (!auto_mode) begin
                    state_next = ST_MANUAL;
                    sel_next   = man_sel;
                end
            end
            default: begin
                state_next = ST_MANUAL;
                sel_next   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/refsw_out.sv
module refsw_out (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sel_next,
    output logic ack,
    output logic evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack <= 1'b0;
            evt <= 1'b0;
        end else begin
            ack <= sel_next;
            evt <= sel_next ^ sel;
        end
    end
endmodule

// File: rtl/refsw_ctrl.sv
module refsw_ctrl
    import refsw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_mode,
    input  logic               man_sel,
    input  logic [NUM_REF-1:0] fault,
    output logic               mux_sel,
    output logic               ref_ack,
    output logic               resel_evt
);
    logic [NUM_REF-1:0] fault_rise;
    refsw_state_e       st;
    logic               sel_d;

    refsw_edge #(.WIDTH(NUM_REF)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (fault),
        .rise (fault_rise)
    );

    refsw_fsm #(.N(NUM_REF)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_mode(auto_mode),
        .man_sel  (man_sel),
        .rise     (fault_rise),
        .state    (st),
        .sel      (mux_sel),
        .sel_next (sel_d)
    );

    refsw_out u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (mux_sel),
        .sel_next(sel_d),
        .ack     (ref_ack),
        .evt     (resel_evt)
    );
endmodule

// File: rtl/refsw_chk.sv
module refsw_chk
    import refsw_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               auto_mode,
    input logic               man_sel,
    input logic [NUM_REF-1:0] fault,
    input logic               mux_sel,
    input logic               ref_ack,
    input logic               resel_evt,
    input refsw_state_e       state
);
    AST_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack == mux_sel); // R3

    AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_mode |=> mux_sel == $past(man_sel)); // R2

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_MANUAL && auto_mode && !fault[mux_sel]) |=> $stable(mux_sel)); // R4

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWITCHED && auto_mode) |=> ($stable(mux_sel) && state == ST_SWITCHED)); // R7

    AST_EVT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> resel_evt == (mux_sel != $past(mux_sel))); // R10
endmodule

bind refsw_ctrl refsw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .auto_mode(auto_mode),
    .man_sel  (man_sel),
    .fault    (fault),
    .mux_sel  (mux_sel),
    .ref_ack  (ref_ack),
    .resel_evt(resel_evt),
    .state    (st)
);

// File: tb/sim_refsw_ctrl.sv
module sim_refsw_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       auto_mode = 1'b0;
    logic       man_sel = 1'b0;
    logic [1:0] fault = 2'b00;
    logic       mux_sel, ref_ack, resel_evt;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        logic  sel;
        logic  evt;
        string req;
    } exp_t;
    exp_t sb[$];

    int         m_st = 0;
    logic       m_sel = 1'b0;
    logic [1:0] m_fq = 2'b00;

    refsw_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_mode(auto_mode),
        .man_sel  (man_sel),
        .fault    (fault),
        .mux_sel  (mux_sel),
        .ref_ack  (ref_ack),
        .resel_evt(resel_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic ms, input logic [1:0] f, input string req);
        logic rise_w;
        logic nsel;
        exp_t e;
        @(negedge clk);
        auto_mode = a;
        man_sel   = ms;
        fault     = f;
        rise_w = f[m_sel] & ~m_fq[m_sel];
        nsel = m_sel;
        case (m_st)
            0: begin nsel = ms; if (a) m_st = 1; end
            1: if (!a) begin m_st = 0; nsel = ms; end
               else if (rise_w) begin m_st = 2; nsel = ~m_sel; end
            default: if (!a) begin m_st = 0; nsel = ms; end
        endcase
        e.sel = nsel;
        e.evt = (nsel != m_sel);
        e.req = req;
        m_sel = nsel;
        m_fq  = f;
        sb.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(mux_sel, e.sel, e.req, "mux_sel");
                check(ref_ack, e.sel, "R3", "ref_ack");
                check(resel_evt, e.evt, "R10", "resel_evt");
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        check(mux_sel, 1'b0, "R1", "reset mux_sel");
        check(ref_ack, 1'b0, "R1", "reset ref_ack");
        check(resel_evt, 1'b0, "R1", "reset resel_evt");
        @(negedge clk);
        rst_n = 1'b1;

        step(0, 1, 2'b00, "R2");
        step(0, 1, 2'b00, "R2");
        step(0, 0, 2'b00, "R2");
        step(1, 0, 2'b00, "R4");
        step(1, 1, 2'b00, "R4");
        step(1, 1, 2'b10, "R6");
        step(1, 1, 2'b00, "R6");
        step(1, 0, 2'b01, "R5");
        step(1, 0, 2'b01, "R7");
        step(1, 0, 2'b11, "R7");
        step(1, 1, 2'b11, "R8");
        step(1, 0, 2'b01, "R8");
        step(0, 1, 2'b00, "R9");
        step(0, 0, 2'b00, "R9");
        step(0, 1, 2'b00, "R9");
        step(1, 1, 2'b00, "R9");
        step(1, 1, 2'b10, "R9");
        step(1, 0, 2'b10, "R7");
        step(0, 0, 2'b00, "R2");
        step(0, 0, 2'b00, "R2");
        @(posedge clk);
        @(negedge clk);
        finished = 1;
        summary();
    end
endmodule